// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor and a word-addressed main memory. It holds 128 lines of 16 words. Each line has a tag, a valid flag and a dirty flag. Every memory block has exactly one line it can occupy. Hits finish in a single cycle and can run back to back. A miss brings in the whole block as a burst. If the line being replaced holds modified data, those 16 words go back to memory first. Writes go to the cache only and reach memory when their line is evicted.

On a read miss the processor does not wait for the burst to finish. The requested word is handed over in the same cycle its beat arrives. A write miss allocates the line and merges the store into the incoming block. A separate invalidate input lets a DMA agent tell the cache that a memory block has changed. The matching line is then dropped, together with any modified data it held.

Top module: `dmc_cache`

## Requirements
- R1: A 16-bit word address splits into tag = bits [15:11], line = bits [10:4] and word = bits [3:0], so block j can only occupy line j mod 128. Two blocks with the same line bits evict each other.
- R2: After reset every line is invalid and the first access to any address misses. The controller is idle with `cpu_ready` = 1, `cpu_done` = 0, and no memory request or writeback asserted.
- R3: A request is accepted on a clock edge where `cpu_req` and `cpu_ready` are both 1. A hit needs the line valid and its stored tag equal to the address tag. A hit raises `cpu_done` in the next cycle, with read data on `cpu_rdata`, and issues no memory traffic.
- R4: A write hit updates only the cached word and marks the line dirty. No writeback occurs until that line is replaced.
- R5: A read miss pulses `mem_fill_req` with the block address. It then takes 16 `mem_fill_valid` beats in ascending word order (0 to 15). `cpu_done` and the requested word appear in the cycle of the beat whose index equals the word offset.
- R6: A miss on a valid dirty line first sends all 16 old words on the writeback port, at ascending addresses of the old block, each advancing only when `mem_wb_ready` is 1. The fill request follows after that.
- R7: A write miss fetches the block, replaces the addressed word with the write data, and leaves the line valid and dirty. `cpu_done` rises one cycle after the last beat, and the other 15 words keep their memory values.
- R8: While writing back, filling or finishing a miss, `cpu_ready` stays 0 and no new request is accepted.
- R9: An `inv_valid` pulse whose `inv_blk` (tag and line bits) matches a resident valid line clears that line's valid and dirty flags, so the next access misses with no writeback. A pulse whose tag differs from the resident tag has no effect.
- R10: An invalidate that names the block currently being fetched for a read miss still lets the requested word reach the processor, but leaves the line invalid at the end of the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | 16 | Read data, valid with `cpu_done` on reads |
| mem_wb_valid | output | 1 | Writeback word offered |
| mem_wb_ready | input | 1 | Memory takes the writeback word |
| mem_wb_addr | output | 16 | Writeback word address |
| mem_wb_data | output | 16 | Writeback word data |
| mem_fill_req | output | 1 | One-cycle block fetch request |
| mem_fill_blk | output | 12 | Block address (tag and line) to fetch |
| mem_fill_valid | input | 1 | Fill beat present |
| mem_fill_data | input | 16 | Fill beat data |
| inv_valid | input | 1 | Invalidate request from DMA agent |
| inv_blk | input | 12 | Block address (tag and line) to invalidate |

## Verification
The hardest condition to reach from the ports is an invalidate that lands in the middle of a read fill for the same block. It must not disturb the forwarded word, yet it must leave the line unusable. The bench starts the read in one thread while a second thread waits for the fetch request and then pulses the invalidate during the beats. A repeat read of the same address must then trigger a new fetch. Dirty eviction is reached by a write hit followed by a read of a conflicting tag on the same line. The memory model keeps the written-back words and returns them on a later refetch, so the round trip of modified data is checked as well.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COMPARE   = 3'd1,
        ST_WRITEBACK = 3'd2,
        ST_FILL      = 3'd3,
        ST_RESPOND   = 3'd4
    } ctrl_st_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 5,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_valid,
    input  logic             fill_dirty,
    input  logic             dirty_set,
    input  logic             inv_req,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q, valid_d;
    logic [LINES-1:0] dirty_q, dirty_d;
    logic             inv_match;

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // fill and dirty_set share the controller's line index
    always_comb begin
        valid_d   = valid_q;
        dirty_d   = dirty_q;
        inv_match = inv_req && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
        if (dirty_set)
            dirty_d[rd_idx] = 1'b1;
        if (inv_match) begin
            valid_d[inv_idx] = 1'b0;
            dirty_d[inv_idx] = 1'b0;
        end
        if (fill_we) begin
            valid_d[rd_idx] = fill_valid;
            dirty_d[rd_idx] = fill_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we)
            tag_q[rd_idx] <= fill_tag;
    end

    // R7 / R10: a completed fill leaves exactly the requested valid flag
    a_r7_fill_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (valid_q[$past(rd_idx)] == $past(fill_valid))
                 && (dirty_q[$past(rd_idx)] == $past(fill_dirty)));

    // R9: a matching invalidate clears the line unless a fill overwrites it
    a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_match && !(fill_we && rd_idx == inv_idx))
            |=> !valid_q[$past(inv_idx)] && !dirty_q[$past(inv_idx)]);

    // R4: a write hit marks the line dirty unless invalidated in the same cycle
    a_r4_dirty_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_set && !(inv_match && inv_idx == rd_idx)) |=> dirty_q[$past(rd_idx)]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int DATA_W = 16,
    parameter int LADDR_W = 11,
    localparam int DEPTH = 1 << LADDR_W
) (
    input  logic               clk,
    input  logic [LADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [LADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = ADDR_W - OFF_W,
    localparam int LADDR_W = IDX_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic               cpu_done,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_wb_valid,
    input  logic               mem_wb_ready,
    output logic [ADDR_W-1:0]  mem_wb_addr,
    output logic [DATA_W-1:0]  mem_wb_data,
    output logic               mem_fill_req,
    output logic [BLK_W-1:0]   mem_fill_blk,
    input  logic               mem_fill_valid,
    input  logic [DATA_W-1:0]  mem_fill_data,
    input  logic               inv_valid,
    input  logic [BLK_W-1:0]   inv_blk,
    output logic [IDX_W-1:0]   ts_idx,
    input  logic [TAG_W-1:0]   ts_tag,
    input  logic               ts_valid,
    input  logic               ts_dirty,
    output logic               ts_fill_we,
    output logic [TAG_W-1:0]   ts_fill_tag,
    output logic               ts_fill_valid,
    output logic               ts_fill_dirty,
    output logic               ts_dirty_set,
    output logic [LADDR_W-1:0] ds_rd_addr,
    input  logic [DATA_W-1:0]  ds_rd_data,
    output logic               ds_wr_en,
    output logic [LADDR_W-1:0] ds_wr_addr,
    output logic [DATA_W-1:0]  ds_wr_data
);
    localparam logic [OFF_W-1:0] LAST_WORD = '1;

    typedef struct packed {
        ctrl_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [OFF_W-1:0]  cnt;
        logic              issued;
        logic              kill;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [TAG_W-1:0] cur_tag;
    logic [IDX_W-1:0] cur_idx;
    logic [OFF_W-1:0] cur_off;
    logic             hit;
    logic             inv_same;

    assign cur_tag = cur_q.addr[ADDR_W-1 -: TAG_W];
    assign cur_idx = cur_q.addr[OFF_W +: IDX_W];
    assign cur_off = cur_q.addr[OFF_W-1:0];
    assign hit     = ts_valid && (ts_tag == cur_tag);
    assign inv_same = inv_valid && (inv_blk == {cur_tag, cur_idx});

    assign ts_idx      = cur_idx;
    assign ts_fill_tag = cur_tag;
    assign ds_rd_addr  = {cur_idx, (cur_q.st == ST_WRITEBACK) ? cur_q.cnt : cur_off};

    always_comb begin
        nxt_d         = cur_q;
        cpu_ready     = 1'b0;
        cpu_done      = 1'b0;
        cpu_rdata     = ds_rd_data;
        mem_wb_valid  = 1'b0;
        mem_wb_addr   = {ts_tag, cur_idx, cur_q.cnt};
        mem_wb_data   = ds_rd_data;
        mem_fill_req  = 1'b0;
        mem_fill_blk  = {cur_tag, cur_idx};
        ts_fill_we    = 1'b0;
        ts_fill_valid = 1'b0;
        ts_fill_dirty = 1'b0;
        ts_dirty_set  = 1'b0;
        ds_wr_en      = 1'b0;
        ds_wr_addr    = {cur_idx, cur_off};
        ds_wr_data    = cur_q.wdata;

        case (cur_q.st)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                if (cpu_req) begin
                    nxt_d.st    = ST_COMPARE;
                    nxt_d.addr  = cpu_addr;
                    nxt_d.we    = cpu_we;
                    nxt_d.wdata = cpu_wdata;
                end
            end
            ST_COMPARE: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    cpu_done  = 1'b1;
                    if (cur_q.we) begin
                        ds_wr_en     = 1'b1;
                        ts_dirty_set = 1'b1;
                    end
                    nxt_d.st = ST_IDLE;
                    if (cpu_req) begin
                        nxt_d.st    = ST_COMPARE;
                        nxt_d.addr  = cpu_addr;
                        nxt_d.we    = cpu_we;
                        nxt_d.wdata = cpu_wdata;
                    end
                end else begin
                    nxt_d.cnt    = '0;
                    nxt_d.issued = 1'b0;
                    nxt_d.kill   = inv_same;
                    nxt_d.st     = (ts_valid && ts_dirty) ? ST_WRITEBACK : ST_FILL;
                end
            end
            ST_WRITEBACK: begin
                mem_wb_valid = 1'b1;
                if (inv_same)
                    nxt_d.kill = 1'b1;
                if (mem_wb_ready) begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == LAST_WORD)
                        nxt_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (!cur_q.issued) begin
                    mem_fill_req = 1'b1;
                    nxt_d.issued = 1'b1;
                end
                if (inv_same)
                    nxt_d.kill = 1'b1;
                if (mem_fill_valid) begin
                    ds_wr_en   = 1'b1;
                    ds_wr_addr = {cur_idx, cur_q.cnt};
                    ds_wr_data = (cur_q.we && cur_q.cnt == cur_off) ? cur_q.wdata
                                                                    : mem_fill_data;
                    if (!cur_q.we && cur_q.cnt == cur_off) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = mem_fill_data;
                    end
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == LAST_WORD) begin
                        ts_fill_we    = 1'b1;
                        ts_fill_valid = cur_q.we || !(cur_q.kill || inv_same);
                        ts_fill_dirty = cur_q.we;
                        nxt_d.st      = ST_RESPOND;
                    end
                end
            end
            ST_RESPOND: begin
                cpu_done = cur_q.we;
                nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    // R8: no request can be taken while memory traffic for a miss is in flight
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wb_valid || mem_fill_valid) |-> !cpu_ready);

    // R6: writeback words leave in ascending address order
    a_r6_wb_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wb_valid && mem_wb_ready && mem_wb_addr[OFF_W-1:0] != LAST_WORD)
            |=> mem_wb_valid && (mem_wb_addr == $past(mem_wb_addr) + 1'b1));

    // R5: an early completion during a fill is a read at the beat matching its offset
    a_r5_forward_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && mem_fill_valid) |-> (cur_q.cnt == cur_off) && !cur_q.we);

    // R3: an accepted request is latched for the tag compare
    a_r3_accept_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> (cur_q.st == ST_COMPARE) && (cur_q.addr == $past(cpu_addr)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = ADDR_W - OFF_W,
    localparam int LADDR_W = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_wb_valid,
    input  logic              mem_wb_ready,
    output logic [ADDR_W-1:0] mem_wb_addr,
    output logic [DATA_W-1:0] mem_wb_data,
    output logic              mem_fill_req,
    output logic [BLK_W-1:0]  mem_fill_blk,
    input  logic              mem_fill_valid,
    input  logic [DATA_W-1:0] mem_fill_data,
    input  logic              inv_valid,
    input  logic [BLK_W-1:0]  inv_blk
);
    logic [IDX_W-1:0]   ts_idx;
    logic [TAG_W-1:0]   ts_tag;
    logic               ts_valid, ts_dirty;
    logic               ts_fill_we, ts_fill_valid, ts_fill_dirty, ts_dirty_set;
    logic [TAG_W-1:0]   ts_fill_tag;
    logic [LADDR_W-1:0] ds_rd_addr, ds_wr_addr;
    logic [DATA_W-1:0]  ds_rd_data, ds_wr_data;
    logic               ds_wr_en;

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_wb_valid(mem_wb_valid), .mem_wb_ready(mem_wb_ready),
        .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data),
        .mem_fill_req(mem_fill_req), .mem_fill_blk(mem_fill_blk),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .inv_valid(inv_valid), .inv_blk(inv_blk),
        .ts_idx(ts_idx), .ts_tag(ts_tag), .ts_valid(ts_valid), .ts_dirty(ts_dirty),
        .ts_fill_we(ts_fill_we), .ts_fill_tag(ts_fill_tag),
        .ts_fill_valid(ts_fill_valid), .ts_fill_dirty(ts_fill_dirty),
        .ts_dirty_set(ts_dirty_set),
        .ds_rd_addr(ds_rd_addr), .ds_rd_data(ds_rd_data),
        .ds_wr_en(ds_wr_en), .ds_wr_addr(ds_wr_addr), .ds_wr_data(ds_wr_data)
    );

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ts_idx), .rd_tag(ts_tag), .rd_valid(ts_valid), .rd_dirty(ts_dirty),
        .fill_we(ts_fill_we), .fill_tag(ts_fill_tag),
        .fill_valid(ts_fill_valid), .fill_dirty(ts_fill_dirty),
        .dirty_set(ts_dirty_set),
        .inv_req(inv_valid),
        .inv_idx(inv_blk[IDX_W-1:0]),
        .inv_tag(inv_blk[BLK_W-1 -: TAG_W])
    );

    dmc_data_store #(.DATA_W(DATA_W), .LADDR_W(LADDR_W)) u_data (
        .clk(clk),
        .rd_addr(ds_rd_addr), .rd_data(ds_rd_data),
        .wr_en(ds_wr_en), .wr_addr(ds_wr_addr), .wr_data(ds_wr_data)
    );
endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SCRAMBLE = 16'h5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [15:0] cpu_rdata;
    logic        mem_wb_valid;
    logic        mem_wb_ready = 1'b0;
    logic [15:0] mem_wb_addr, mem_wb_data;
    logic        mem_fill_req;
    logic [11:0] mem_fill_blk;
    logic        mem_fill_valid = 1'b0;
    logic [15:0] mem_fill_data = '0;
    logic        inv_valid = 1'b0;
    logic [11:0] inv_blk = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_cache uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_wb_valid(mem_wb_valid), .mem_wb_ready(mem_wb_ready),
        .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data),
        .mem_fill_req(mem_fill_req), .mem_fill_blk(mem_fill_blk),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .inv_valid(inv_valid), .inv_blk(inv_blk)
    );

    int nvec = 0, nbad = 0;
    int fills = 0, wbs = 0, r8_bad = 0, beat_idx = 0;
    logic [15:0] wb_log_addr [16];
    logic [15:0] wb_log_data [16];
    logic [11:0] ovr_blk = '0;
    logic        ovr_ok = 1'b0;
    logic [15:0] ovr_data [16];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: default contents are address ^ SCRAMBLE; last written-back block is kept
    initial begin
        forever begin
            @(posedge clk);
            #1 mem_wb_ready = ~mem_wb_ready;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (mem_fill_req) begin
                automatic logic [11:0] blk = mem_fill_blk;
                fills++;
                @(posedge clk);
                @(posedge clk);
                for (int b = 0; b < 16; b++) begin
                    #1;
                    mem_fill_valid = 1'b1;
                    beat_idx = b;
                    mem_fill_data = (ovr_ok && blk == ovr_blk) ? ovr_data[b]
                                                               : ({blk, b[3:0]} ^ SCRAMBLE);
                    @(posedge clk);
                end
                #1 mem_fill_valid = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_wb_valid && mem_wb_ready) begin
            wb_log_addr[wbs % 16] = mem_wb_addr;
            wb_log_data[wbs % 16] = mem_wb_data;
            ovr_blk = mem_wb_addr[15:4];
            ovr_data[mem_wb_addr[3:0]] = mem_wb_data;
            ovr_ok = 1'b1;
            wbs++;
        end
        if (rst_n && (mem_wb_valid || mem_fill_valid) && cpu_ready)
            r8_bad++;
    end

    task automatic access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output int lat, output int fwd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        while (!cpu_ready) @(negedge clk);
        @(posedge clk);
        lat = 0; fwd = -1; rd = '0;
        forever begin
            @(negedge clk);
            if (lat == 0) cpu_req = 1'b0;
            lat++;
            if (cpu_done) begin
                rd = cpu_rdata;
                if (mem_fill_valid) fwd = beat_idx;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        chk;
        logic        miss;
        logic [4:0]  nwb;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 16'h0123, 16'h0000, 16'h5B79, 1'b1, 1'b1, 5'd0},   // R2 cold miss
        '{1'b0, 16'h012F, 16'h0000, 16'h5B75, 1'b1, 1'b0, 5'd0},   // R3 hit same block
        '{1'b1, 16'h0125, 16'h1111, 16'h0000, 1'b0, 1'b0, 5'd0},   // R4 write hit
        '{1'b0, 16'h0125, 16'h0000, 16'h1111, 1'b1, 1'b0, 5'd0},   // R4 readback
        '{1'b1, 16'h3450, 16'h2222, 16'h0000, 1'b0, 1'b1, 5'd0},   // R7 write miss
        '{1'b0, 16'h345F, 16'h0000, 16'h6E05, 1'b1, 1'b0, 5'd0},   // R7 other word kept
        '{1'b0, 16'h3450, 16'h0000, 16'h2222, 1'b1, 1'b0, 5'd0},   // R7 merged word
        '{1'b0, 16'h0923, 16'h0000, 16'h5379, 1'b1, 1'b1, 5'd16},  // R1 R6 conflict, dirty
        '{1'b0, 16'h0125, 16'h0000, 16'h1111, 1'b1, 1'b1, 5'd0},   // R6 data came back
        '{1'b0, 16'h0F00, 16'h0000, 16'h555A, 1'b1, 1'b1, 5'd0},   // R5 forward at beat 0
        '{1'b0, 16'h1F0F, 16'h0000, 16'h4555, 1'b1, 1'b1, 5'd0},   // R5 forward at beat 15
        '{1'b1, 16'h1F03, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 5'd0}    // R4 write hit
    };

    task automatic run_all();
        logic [15:0] rd;
        int lat, fwd, f0, w0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle state after reset
        chk(cpu_ready === 1'b1, "R2 ready", int'(cpu_ready), 1);
        chk(cpu_done === 1'b0 && mem_wb_valid === 1'b0 && mem_fill_req === 1'b0,
            "R2 quiet", int'({cpu_done, mem_wb_valid, mem_fill_req}), 0);

        for (int i = 0; i < 12; i++) begin
            f0 = fills; w0 = wbs;
            access(VEC[i].we, VEC[i].addr, VEC[i].wd, rd, lat, fwd);
            if (VEC[i].chk)
                chk(rd == VEC[i].exp, "R3/R5 read data", int'(rd), int'(VEC[i].exp));
            chk((fills - f0) == int'(VEC[i].miss), "R1 R3 hit or miss", fills - f0, int'(VEC[i].miss));
            chk((wbs - w0) == int'(VEC[i].nwb), "R4 R6 writeback count", wbs - w0, int'(VEC[i].nwb));
            if (!VEC[i].miss)
                chk(lat == 1, "R3 hit latency", lat, 1);
            if (VEC[i].miss && !VEC[i].we)
                chk(fwd == int'(VEC[i].addr[3:0]), "R5 forward beat", fwd, int'(VEC[i].addr[3:0]));
        end

        // R6 / R1: evicted block written back word by word at old-tag addresses
        for (int k = 0; k < 16; k++) begin
            chk(wb_log_addr[k] == 16'h0120 + 16'(k), "R6 wb address", int'(wb_log_addr[k]),
                int'(16'h0120 + 16'(k)));
            chk(wb_log_data[k] == ((k == 5) ? 16'h1111 : ((16'h0120 + 16'(k)) ^ SCRAMBLE)),
                "R6 wb data", int'(wb_log_data[k]),
                int'((k == 5) ? 16'h1111 : ((16'h0120 + 16'(k)) ^ SCRAMBLE)));
        end

        // R9: invalidate with a different tag on the same line leaves the line alone
        @(negedge clk); inv_valid = 1'b1; inv_blk = 12'h0F0;
        @(negedge clk); inv_valid = 1'b0;
        f0 = fills; w0 = wbs;
        access(1'b0, 16'h1F03, 16'h0, rd, lat, fwd);
        chk(rd == 16'hBEEF && fills == f0, "R9 mismatch ignored", int'(rd), int'(16'hBEEF));

        // R9: matching invalidate drops the dirty line without writeback
        @(negedge clk); inv_valid = 1'b1; inv_blk = 12'h1F0;
        @(negedge clk); inv_valid = 1'b0;
        f0 = fills; w0 = wbs;
        access(1'b0, 16'h1F03, 16'h0, rd, lat, fwd);
        chk(fills - f0 == 1, "R9 refetch after invalidate", fills - f0, 1);
        chk(wbs == w0, "R9 dirty data discarded", wbs - w0, 0);
        chk(rd == 16'h4559, "R9 memory data", int'(rd), int'(16'h4559));

        // R10: invalidate of the block in flight during a read fill
        f0 = fills;
        fork
            access(1'b0, 16'h2A07, 16'h0, rd, lat, fwd);
            begin
                wait (mem_fill_req === 1'b1);
                @(posedge clk); @(posedge clk); @(posedge clk);
                #1 inv_valid = 1'b1; inv_blk = 12'h2A0;
                @(posedge clk);
                #1 inv_valid = 1'b0;
            end
        join
        chk(rd == 16'h705D, "R10 word still forwarded", int'(rd), int'(16'h705D));
        access(1'b0, 16'h2A07, 16'h0, rd, lat, fwd);
        chk(fills - f0 == 2, "R10 line left invalid", fills - f0, 2);

        chk(r8_bad == 0, "R8 ready low while busy", r8_bad, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                nbad++;
                nvec++;
                $display("FAIL watchdog R2-R10 actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule